// File: doc/BRIEF.md
# Reconfigurable Four-Line Reversible Gate

This block applies one of 32 reversible gates to a 4-bit data word. A 5-bit configuration word selects the gate. The choices are the 4 single-line inverters, the 12 singly controlled inverters, the 12 doubly controlled inverters and the 4 triply controlled inverters that can act on four lines, all with positive control polarity. The configuration picks a target line and which of the remaining lines act as controls. The gate inverts the target when every enabled control line is 1.

Internally the block is a fixed cascade of 13 reversible elements on a 12-line word. Three controlled swaps steer the chosen target into a fixed slot. Three mixed-polarity Toffoli stages then load three constant-1 ancilla lines with either a data line or a steady 1. A positive 4-input Toffoli core acts on the target slot. Three more Toffoli stages return the ancillas to 1, and three swaps undo the steering. The configuration and ancilla lines are passed to the outputs as well, so the block has no garbage outputs and can be chained. All outputs are registered once.

Top module: `rrg_gate4`

## Requirements
- R1: With `rst` high at a rising edge, all outputs are 0 after that edge.
- R2: Every output changes only at a rising edge. It shows the result of the inputs sampled at that edge, so latency is one cycle.
- R3: `cfg_o` equals the `cfg_i` sampled one edge earlier.
- R4: When `anc_i` is 3'b111, `anc_o` one cycle later is 3'b111 for every configuration and data value.
- R5: The target data line is `cfg_i[1:0]`, read as a binary index into `data_i`. No other data bit can differ between input and output.
- R6: Control enables `cfg_i[2]`, `cfg_i[3]` and `cfg_i[4]` map to data lines according to the target. For target 0 they map to lines 1, 2, 3. For target 1 they map to 0, 3, 2. For target 2 they map to 1, 0, 3. For target 3 they map to 0, 1, 2.
- R7: The target bit inverts exactly when every enabled control line is 1. With no enable set, the target always inverts.
- R8: For each of the 32 configurations, the map from `data_i` to `data_o` is a bijection on the 16 data values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | 5 | Target index in [1:0], control enables in [4:2] |
| data_i | input | 4 | Data lines |
| anc_i | input | 3 | Constant ancilla lines, tied to 1 in use |
| cfg_o | output | 5 | Registered configuration pass-through |
| data_o | output | 4 | Registered gate result |
| anc_o | output | 3 | Registered ancilla lines, restored to 1 |

## Verification
A wrong swap or a wrong control tap appears one cycle later in one of two ways. A data bit other than the indexed target flips, or the target flips for a control pattern where it should hold. An ancilla stage that fails to restore its line shows up in the same cycle as a 0 on `anc_o`. The bench sweeps all 512 configuration and data pairs. For each configuration it also checks that all 16 outputs are distinct, so any mapping that is not a bijection is caught within that configuration's sweep.

// File: rtl/rrg_pkg.sv
package rrg_pkg;
  localparam int CFG_W  = 5;
  localparam int ANC_W  = 3;
  localparam int DAT_W  = 4;
  localparam int SEL_W  = $clog2(DAT_W);
  localparam int LINE_W = CFG_W + ANC_W + DAT_W;
  localparam int CFG_LO = 0;
  localparam int ANC_LO = CFG_W;
  localparam int DAT_LO = CFG_W + ANC_W;
  localparam int N_ROUTE = 3;
  localparam int N_STAGE = 4 * N_ROUTE + 1;

  typedef logic [LINE_W-1:0] line_t;

  // steering swaps: index i is applied in ascending order on the way in
  function automatic int route_ctl(input int i);
    return (i == 2) ? CFG_LO + 1 : CFG_LO;
  endfunction

  function automatic int route_a(input int i);
    return (i == 1) ? DAT_LO + 2 : DAT_LO;
  endfunction

  function automatic int route_b(input int i);
    case (i)
      0:       return DAT_LO + 1;
      1:       return DAT_LO + 3;
      default: return DAT_LO + 2;
    endcase
  endfunction
endpackage

// File: rtl/rrg_fredkin.sv
module rrg_fredkin
  import rrg_pkg::*;
#(
  parameter int CTL    = 0,
  parameter int SWAP_A = DAT_LO,
  parameter int SWAP_B = DAT_LO + 1
) (
  input  line_t line_i,
  output line_t line_o
);
  always_comb begin
    line_o = line_i;
    if (line_i[CTL]) begin
      line_o[SWAP_A] = line_i[SWAP_B];
      line_o[SWAP_B] = line_i[SWAP_A];
    end
  end
endmodule

// File: rtl/rrg_toffoli.sv
module rrg_toffoli
  import rrg_pkg::*;
#(
  parameter int          NCTL = 3,
  parameter int          CTL0 = 0,
  parameter int          CTL1 = 0,
  parameter int          CTL2 = 0,
  parameter logic [2:0]  POL  = 3'b111,
  parameter int          TGT  = 0
) (
  input  line_t line_i,
  output line_t line_o
);
  localparam logic [2:0] USED = 3'((1 << NCTL) - 1);

  logic [2:0] hit;
  logic       fire;

  assign hit[0] = (line_i[CTL0] == POL[0]);
  assign hit[1] = (line_i[CTL1] == POL[1]);
  assign hit[2] = (line_i[CTL2] == POL[2]);
  assign fire   = &(hit | ~USED);

  always_comb begin
    line_o      = line_i;
    line_o[TGT] = line_i[TGT] ^ fire;
  end
endmodule

// File: rtl/rrg_gate4.sv
module rrg_gate4
  import rrg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [DAT_W-1:0] data_i,
  input  logic [ANC_W-1:0] anc_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic [DAT_W-1:0] data_o,
  output logic [ANC_W-1:0] anc_o
);
  localparam int FEED_BASE = N_ROUTE;
  localparam int CORE_IDX  = 2 * N_ROUTE;
  localparam int REST_BASE = CORE_IDX + 1;
  localparam int BACK_BASE = REST_BASE + N_ROUTE;

  line_t st [0:N_STAGE];

  assign st[0] = {data_i, anc_i, cfg_i};

  genvar gi;
  generate
    for (gi = 0; gi < N_ROUTE; gi++) begin : g_steer
      rrg_fredkin #(.CTL(route_ctl(gi)), .SWAP_A(route_a(gi)), .SWAP_B(route_b(gi)))
        u_fwd (.line_i(st[gi]), .line_o(st[gi + 1]));
      rrg_fredkin #(.CTL(route_ctl(N_ROUTE - 1 - gi)), .SWAP_A(route_a(N_ROUTE - 1 - gi)),
                    .SWAP_B(route_b(N_ROUTE - 1 - gi)))
        u_back (.line_i(st[BACK_BASE + gi]), .line_o(st[BACK_BASE + gi + 1]));
    end

    // ancilla k becomes (not enable) or (control slot k+1)
    for (gi = 0; gi < ANC_W; gi++) begin : g_anc
      rrg_toffoli #(.NCTL(2), .CTL0(CFG_LO + SEL_W + gi), .CTL1(DAT_LO + 1 + gi),
                    .CTL2(0), .POL(3'b001), .TGT(ANC_LO + gi))
        u_feed (.line_i(st[FEED_BASE + gi]), .line_o(st[FEED_BASE + gi + 1]));
      rrg_toffoli #(.NCTL(2), .CTL0(CFG_LO + SEL_W + ANC_W - 1 - gi),
                    .CTL1(DAT_LO + ANC_W - gi), .CTL2(0), .POL(3'b001),
                    .TGT(ANC_LO + ANC_W - 1 - gi))
        u_rest (.line_i(st[REST_BASE + gi]), .line_o(st[REST_BASE + gi + 1]));
    end
  endgenerate

  rrg_toffoli #(.NCTL(3), .CTL0(ANC_LO), .CTL1(ANC_LO + 1), .CTL2(ANC_LO + 2),
                .POL(3'b111), .TGT(DAT_LO))
    u_core (.line_i(st[CORE_IDX]), .line_o(st[CORE_IDX + 1]));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o  <= '0;
      data_o <= '0;
      anc_o  <= '0;
    end else begin
      cfg_o  <= st[N_STAGE][CFG_LO +: CFG_W];
      data_o <= st[N_STAGE][DAT_LO +: DAT_W];
      anc_o  <= st[N_STAGE][ANC_LO +: ANC_W];
    end
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_CFG_PASS: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> cfg_o == $past(cfg_i)); // R3
  AST_ANC_RESTORED: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(&anc_i) |-> &anc_o); // R4
  AST_ONE_FLIP_MAX: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> $countones(data_o ^ $past(data_i)) <= 1); // R5
  AST_TARGET_ONLY: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((data_o ^ $past(data_i)) &
                 ~({{(DAT_W-1){1'b0}}, 1'b1} << $past(cfg_i[SEL_W-1:0]))) == '0); // R5
  AST_PLAIN_INVERT: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(cfg_i[CFG_W-1:SEL_W]) == '0 && $past(&anc_i)
      |-> $countones(data_o ^ $past(data_i)) == 1); // R7
endmodule

// File: tb/rrg_gate4_bench.sv
module rrg_gate4_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] cfg = '0;
  logic [3:0] data = '0;
  logic [2:0] anc = 3'b111;
  logic [4:0] cfg_o;
  logic [3:0] data_o;
  logic [2:0] anc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rrg_gate4 u_rrg_gate4 (
    .clk(clk), .rst(rst), .cfg_i(cfg), .data_i(data), .anc_i(anc),
    .cfg_o(cfg_o), .data_o(data_o), .anc_o(anc_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R6: control line wired to enable k for target t
  function automatic int ctl_line(input int t, input int k);
    case (t)
      0:       return k + 1;
      1:       return (k == 0) ? 0 : ((k == 1) ? 3 : 2);
      2:       return (k == 0) ? 1 : ((k == 1) ? 0 : 3);
      default: return k;
    endcase
  endfunction

  function automatic logic [3:0] model(input logic [4:0] c, input logic [3:0] d);
    int  t;
    bit  fire;
    t    = int'(c[1:0]);
    fire = 1'b1;
    for (int k = 0; k < 3; k++)
      if (c[2 + k] && !d[ctl_line(t, k)]) fire = 1'b0;
    return d ^ (4'(fire) << t);
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    logic [15:0] seen;
    logic [3:0]  exp_d;
    logic [4:0]  prev_cfg;
    logic [3:0]  prev_d;
    repeat (3) @(negedge clk);
    chk(cfg_o == 0 && data_o == 0 && anc_o == 0, "R1 reset outputs",
        {cfg_o, data_o, anc_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    prev_cfg = cfg_o;
    prev_d   = data_o;
    for (int c = 0; c < 32; c++) begin
      seen = '0;
      for (int d = 0; d < 16; d++) begin
        cfg  = 5'(c);
        data = 4'(d);
        #1;
        if (d == 0)
          chk(cfg_o == prev_cfg && data_o == prev_d, "R2 no change before edge",
              {cfg_o, data_o}, {prev_cfg, prev_d});
        @(negedge clk);
        exp_d = model(5'(c), 4'(d));
        chk(data_o == exp_d, "R6 R7 gate result", data_o, exp_d);
        chk(((data_o ^ 4'(d)) & ~(4'b1 << c[1:0])) == 0, "R5 non-target bits",
            data_o, d);
        chk(anc_o == 3'b111, "R4 ancilla restore", anc_o, 3'b111);
        chk(cfg_o == 5'(c), "R3 config pass", cfg_o, c);
        seen[data_o] = 1'b1;
        prev_cfg = cfg_o;
        prev_d   = data_o;
      end
      chk(seen == 16'hFFFF, "R8 bijection", seen, 16'hFFFF);
    end
    // directed corners: four-input gate on line 2 fires only at all-ones controls
    cfg = 5'b11110; data = 4'b1011;
    @(negedge clk);
    chk(data_o == 4'b1111, "R7 full control fire", data_o, 4'b1111);
    data = 4'b1010;
    @(negedge clk);
    chk(data_o == 4'b1010, "R7 full control hold", data_o, 4'b1010);
    // R6: target 1, enable only bit 3 -> control is line 3
    cfg = 5'b01001; data = 4'b1000;
    @(negedge clk);
    chk(data_o == 4'b1010, "R6 target1 enable3", data_o, 4'b1010);
    // mid-run reset
    rst = 1'b1;
    @(negedge clk);
    chk(cfg_o == 0 && data_o == 0 && anc_o == 0, "R1 mid-run reset",
        {cfg_o, data_o, anc_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(data_o == 4'b1010 && cfg_o == 5'b01001, "R2 recovery after reset",
        {cfg_o, data_o}, {5'b01001, 4'b1010});
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end
endmodule